// File: doc/BRIEF.md
# Rotate-Through-Temp Barrel Shifter

This block is a 16-bit shifter with its own holding register, here called the spill register. The spill register sits beside the shifter and is not part of any register file. Each operation takes a source word, a 4-bit amount and a 2-bit operation code, and returns a result in the same cycle. When the strobe `valid_i` is high, the spill register is updated at the next rising clock edge.

Four operations are available:
- **Plain rotate right.**
- **Rotate through spill.** This works like rotate-through-carry extended to N bits. The N bits that leave the low end of the source go into the spill register. The N top bits of the spill register enter the result at the same positions.
- **Frame extraction.** A 16-bit window is taken from the 32-bit pair formed by the spill register above the source.
- **Pass-through.**

Rotate and frame extraction share one right-shifting barrel network. A magnitude mask selects the positions where bits are exchanged with the spill register. The mask holds N ones packed down from the most significant bit, and it is zero in every mode except rotate-through-spill.

Top module: `rtt_shifter`

## Requirements
- R1: While `rst_n` is low, the spill register (`spill_o`) is cleared to 0x0000.
- R2: Code 2'b00 (rotate): `result_o` bit i equals `src_i` bit (i+N) mod 16, where N = `amt_i`. The spill register does not change.
- R3: Code 2'b01 (rotate through spill): at positions 15 down to 16-N, `result_o` takes the same bit positions of the spill register. The remaining positions hold the rotate-right value of R2.
- R4: Code 2'b01 with `valid_i` high: at the next rising edge, the spill register positions 15 down to 16-N take the rotate-right value at those positions. All other spill bits keep their value.
- R5: When `valid_i` is low, the spill register never changes, whatever the operation code.
- R6: Code 2'b10 (frame): `result_o` equals bits [N+15:N] of the 32-bit value {spill, `src_i`}. The spill register does not change.
- R7: Code 2'b11 (pass): `result_o` equals `src_i` for any amount. The spill register does not change.
- R8: With N = 0, every operation returns `src_i`, and the spill register is unchanged even with `valid_i` high.
- R9: `result_o` depends combinationally on the current inputs. It uses the spill value held before the edge that applies the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| valid_i | input | 1 | Strobe that allows the spill register to update on this edge |
| op_i | input | 2 | Operation: 00 rotate, 01 rotate through spill, 10 frame, 11 pass |
| amt_i | input | 4 | Shift amount N, 0 to 15 |
| src_i | input | 16 | Source word |
| result_o | output | 16 | Shifted result |
| spill_o | output | 16 | Current spill register contents |

## Verification
The bench builds the block with the default WIDTH of 16, so the amount field is 4 bits wide. That size makes a full sweep of all 16 amounts in every mode short. Chained rotate-through-spill operations carry the spill state from one vector into the next, which exposes any mistake in mask placement or in keeping unmasked bits. The sweeps include the extremes N = 0 and N = 15, operations with the strobe low, and frame windows that reach into the top of the spill register.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    OP_ROR   = 2'b00,
    OP_RTT   = 2'b01,
    OP_FRAME = 2'b10,
    OP_PASS  = 2'b11
  } rtt_op_e;
endpackage

// File: rtl/rtt_mask_dec.sv
module rtt_mask_dec #(
  parameter  int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             en_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0] mask_o
);
  localparam logic [AMT_W:0] FULL = (AMT_W+1)'(WIDTH);

  logic [AMT_W:0] thresh;

  always_comb begin
    thresh = FULL - {1'b0, amt_i};
  end

  // bit i is set when i >= WIDTH - N: N ones packed from the top
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign mask_o[i] = en_i && ((AMT_W+1)'(i) >= thresh);
  end
endmodule

// File: rtl/rtt_funnel.sv
module rtt_funnel #(
  parameter  int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] lo_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0] out_o
);
  logic [2*WIDTH-1:0] stg [AMT_W+1];

  assign stg[0] = {hi_i, lo_i};

  // one 2:1 mux stage per amount bit, weights 1, 2, 4, ...
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    assign stg[k+1] = amt_i[k] ? (stg[k] >> (1 << k)) : stg[k];
  end

  assign out_o = stg[AMT_W][WIDTH-1:0];
endmodule

// File: rtl/rtt_spill_reg.sv
module rtt_spill_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (we_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end

  AST_SPILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/rtt_shifter.sv
module rtt_shifter
  import rtt_pkg::*;
#(
  parameter  int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] spill_o
);
  rtt_op_e          op;
  logic [WIDTH-1:0] funnel_hi;
  logic [AMT_W-1:0] eff_amt;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] spill_q;
  logic [WIDTH-1:0] spill_d;
  logic             mask_en;
  logic             spill_we;

  assign op = rtt_op_e'(op_i);

  // operand steering for the shared funnel
  always_comb begin
    funnel_hi = src_i;
    eff_amt   = amt_i;
    unique case (op)
      OP_ROR:   funnel_hi = src_i;
      OP_RTT:   funnel_hi = src_i;
      OP_FRAME: funnel_hi = spill_q;
      OP_PASS:  eff_amt   = '0;
      default:  eff_amt   = '0;
    endcase
  end

  assign mask_en  = (op == OP_RTT);
  assign spill_we = valid_i && (op == OP_RTT);

  rtt_funnel #(.WIDTH(WIDTH)) u_funnel (
    .hi_i  (funnel_hi),
    .lo_i  (src_i),
    .amt_i (eff_amt),
    .out_o (shifted)
  );

  rtt_mask_dec #(.WIDTH(WIDTH)) u_mask (
    .en_i   (mask_en),
    .amt_i  (amt_i),
    .mask_o (mask)
  );

  // per-bit swap between rotated source and spill
  always_comb begin
    result_o = (shifted & ~mask) | (spill_q & mask);
    spill_d  = (spill_q & ~mask) | (shifted & mask);
  end

  rtt_spill_reg #(.WIDTH(WIDTH)) u_spill (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (spill_we),
    .d_i   (spill_d),
    .q_o   (spill_q)
  );

  assign spill_o = spill_q;

  AST_PASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PASS) |-> (result_o == src_i)); // R7
  AST_ZERO_AMT_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_i == '0) |-> (result_o == src_i)); // R8
  AST_MASK_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask) == (mask_en ? int'(amt_i) : 0)); // R3
  AST_SWAP_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RTT) |-> ($countones(src_i) + $countones(spill_q)
                          == $countones(result_o) + $countones(spill_d))); // R4
  AST_SPILL_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_RTT) |=>
      (((spill_q ^ $past(spill_q)) & ~$past(mask)) == '0)); // R4
  AST_NON_RTT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_RTT) |=> $stable(spill_q)); // R6
endmodule

// File: tb/tb_rtt_shifter.sv
module tb_rtt_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  op_i;
  logic [3:0]  amt_i;
  logic [15:0] src_i;
  logic [15:0] result_o;
  logic [15:0] spill_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] spill_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtt_shifter dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .amt_i(amt_i), .src_i(src_i), .result_o(result_o), .spill_o(spill_o)
  );

  function automatic logic [15:0] ref_ror(input logic [15:0] s, input int n);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = s[(i + n) % 16];
    return r;
  endfunction

  function automatic logic [15:0] ref_mask(input int n);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (i >= 16 - n);
    return m;
  endfunction

  function automatic logic [15:0] ref_frame(input logic [15:0] t,
                                            input logic [15:0] s, input int n);
    logic [31:0] c;
    logic [15:0] r;
    c = {t, s};
    for (int i = 0; i < 16; i++) r[i] = c[i + n];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation, check result before the edge, spill after it
  task automatic apply(input string req, input logic [1:0] op, input int n,
                       input logic [15:0] s, input logic v);
    logic [15:0] exp_res, exp_sp, rot, m;
    @(negedge clk);
    op_i = op; amt_i = 4'(n); src_i = s; valid_i = v;
    rot = ref_ror(s, n);
    m   = ref_mask(n);
    exp_sp = spill_m;
    case (op)
      2'b00: exp_res = rot;
      2'b01: begin
        exp_res = (rot & ~m) | (spill_m & m);
        if (v) exp_sp = (spill_m & ~m) | (rot & m);
      end
      2'b10: exp_res = ref_frame(spill_m, s, n);
      default: exp_res = s;
    endcase
    #1;
    check({req, " result"}, result_o, exp_res);
    @(posedge clk); #1;
    spill_m = exp_sp;
    check({req, " spill"}, spill_o, exp_sp);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; valid_i = 1'b0; op_i = 2'b00; amt_i = '0; src_i = '0;
    repeat (3) @(posedge clk);
    #1;
    spill_m = '0;
    check("R1 reset", spill_o, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_ror_r2();
    for (int n = 0; n < 16; n++) apply("R2 ror", 2'b00, n, 16'hA5C3, 1'b1);
    for (int n = 0; n < 16; n++) apply("R2 ror", 2'b00, n, 16'h0001, 1'b1);
  endtask

  task automatic t_rtt_chain_r3_r4();
    for (int n = 0; n < 16; n++) apply("R3/R4 rtt", 2'b01, n, 16'hF00D ^ 16'(n * 16'h1357), 1'b1);
    apply("R4 rtt n15", 2'b01, 15, 16'hFFFF, 1'b1);
    apply("R4 rtt n1", 2'b01, 1, 16'h0000, 1'b1);
    apply("R3 rtt n7", 2'b01, 7, 16'h1234, 1'b1);
  endtask

  task automatic t_no_strobe_r5();
    apply("R5 rtt strobe low", 2'b01, 9, 16'h5AA5, 1'b0);
    apply("R5 rtt strobe low", 2'b01, 15, 16'hFFFF, 1'b0);
    apply("R5 frame strobe low", 2'b10, 4, 16'h0F0F, 1'b0);
  endtask

  task automatic t_frame_r6();
    apply("R6 seed", 2'b01, 15, 16'hBEEF, 1'b1);
    for (int n = 0; n < 16; n++) apply("R6 frame", 2'b10, n, 16'h6C39, 1'b1);
  endtask

  task automatic t_pass_r7();
    for (int n = 0; n < 16; n += 5) apply("R7 pass", 2'b11, n, 16'hC0DE, 1'b1);
  endtask

  task automatic t_zero_amt_r8();
    for (int op = 0; op < 4; op++) apply("R8 zero amount", 2'(op), 0, 16'h8421, 1'b1);
  endtask

  task automatic t_comb_r9();
    // result follows src within the cycle, with the pre-edge spill value
    @(negedge clk);
    op_i = 2'b10; amt_i = 4'd8; valid_i = 1'b0; src_i = 16'h00FF;
    #1 check("R9 comb a", result_o, ref_frame(spill_m, 16'h00FF, 8));
    src_i = 16'hAB00;
    #1 check("R9 comb b", result_o, ref_frame(spill_m, 16'hAB00, 8));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_ror_r2();
    t_rtt_chain_r3_r4();
    t_no_strobe_r5();
    t_frame_r6();
    t_pass_r7();
    t_zero_amt_r8();
    t_comb_r9();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule